// File: doc/BRIEF.md
# Six-Lane Convolution and Dot-Product Engine

This block is the arithmetic core of a small neural-network inference datapath. It has six identical lanes, and each lane multiplies 25 operand pairs and sums the products. The block forms all 150 products in the same cycle. One multiplier array serves two kinds of layer, chosen by a mode input.

In convolution mode the six lanes read the same 5×5 input window, which is the data slice of lane 0. Each lane applies its own kernel, so one operand set yields one output pixel in six feature maps. The layer controller moves the window by one pixel per operand set. In dot-product mode each lane reads its own 25-element slice of the input vector and its own slice of the weights.

A vector longer than 25 elements is split into chunks and fed over several passes with accumulation enabled. A clear input empties the accumulators. Each result is rounded and saturated to the 12-bit working format, which has 6 integer bits and 6 fractional bits. Every result appears a fixed three cycles after its operands, and the block accepts a new operand set in every cycle.

Top module: `conv_dot_engine`

## Requirements
- R1: For lane l, the output is the saturated, rounded value of the sum over t = 0..24 of data × weight. Operand element (l, t) occupies bits [(l·25+t)·12 +: 12] of both operand buses. Lane l's result occupies bits [l·12 +: 12] of `result`.
- R2: When `mode` is 0 (convolution), every lane takes its data from lane 0's data slice and its weights from its own weight slice. The data slices of lanes 1 to 5 have no effect.
- R3: When `mode` is 1 (dot product), every lane takes its data from its own data slice.
- R4: All operands are two's complement with 6 fractional bits. A wide sum S is converted by computing floor((S + 32) / 64), which rounds a half LSB upward.
- R5: A converted value above 2047 gives 2047, and a value below −2048 gives −2048.
- R6: `out_valid` is high in cycle c+3 exactly when `in_valid` was high in cycle c. Operand sets may arrive on consecutive cycles, and each one produces its own result.
- R7: With `acc_en` high, the lane's new chunk sum is added to its wide accumulated sum before conversion. With `acc_en` low, the chunk sum alone is used.
- R8: `acc_clr` high in a cycle zeroes every accumulator at the next edge. Clear takes priority over an accumulation update at the same edge.
- R9: While `out_valid` is low, `result` keeps its value.
- R10: Reset (active-low `rst_n`, asynchronous) drives `out_valid` and `result` to 0 and empties the accumulators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set present this cycle |
| mode | input | 1 | 0 = convolution (shared window), 1 = dot product |
| acc_en | input | 1 | Add this chunk to the lane's previous sum |
| acc_clr | input | 1 | Zero all accumulators |
| data_in | input | 1800 | 150 data operands, 12 bits each |
| weight_in | input | 1800 | 150 weight operands, 12 bits each |
| out_valid | output | 1 | Results present this cycle |
| result | output | 72 | Six saturated 12-bit results |

## Verification
Every operand set must produce its six results exactly three cycles after the bench drives it, in the same order the sets were issued. For each issued set the bench computes the expected results, including the accumulation state, and records the issue cycle next to them. A monitor compares each `out_valid` cycle against the oldest pending entry and checks that it lands at the issue cycle plus three. A final comparison of issued and received counts catches a dropped result. Idle stretches are checked to confirm that the held result does not change.

// File: rtl/conv_dot_engine.sv
`timescale 1ns/1ps
module conv_dot_engine #(
  parameter int LANES     = 6,
  parameter int TAPS      = 25,
  parameter int W         = 12,
  parameter int FRAC      = 6,
  parameter int ACC_GUARD = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  mode,
  input  logic                  acc_en,
  input  logic                  acc_clr,
  input  logic [LANES*TAPS*W-1:0] data_in,
  input  logic [LANES*TAPS*W-1:0] weight_in,
  output logic                  out_valid,
  output logic [LANES*W-1:0]    result
);
  localparam int PW   = 2*W;
  localparam int SW   = PW + $clog2(TAPS);
  localparam int AW   = SW + ACC_GUARD;
  localparam int NP   = LANES*TAPS;
  localparam int MAXI = 2**(W-1) - 1;
  localparam int MINI = -(2**(W-1));

  logic signed [AW-1:0] maxv, minv;
  assign maxv = AW'(MAXI);
  assign minv = AW'(MINI);

  logic signed [PW-1:0] prod_d [NP];
  logic signed [PW-1:0] prod_q [NP];
  logic signed [SW-1:0] sum_d  [LANES];
  logic signed [AW-1:0] acc_q  [LANES];
  logic signed [AW-1:0] rnd    [LANES];
  logic signed [W-1:0]  res_q  [LANES];
  logic v1, v2, acc_en1;

  // stage 1: all products at once; convolution broadcasts lane 0's window
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      for (int t = 0; t < TAPS; t++) begin
        logic signed [W-1:0] a, b;
        a = mode ? data_in[(l*TAPS+t)*W +: W] : data_in[t*W +: W];
        b = weight_in[(l*TAPS+t)*W +: W];
        prod_d[l*TAPS+t] = a * b;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      for (int i = 0; i < NP; i++) prod_q[i] <= prod_d[i];
      acc_en1 <= acc_en;
    end
  end

  // stage 2: per-lane sum and accumulation
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      sum_d[l] = '0;
      for (int t = 0; t < TAPS; t++) sum_d[l] = sum_d[l] + SW'(prod_q[l*TAPS+t]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      out_valid <= 1'b0;
      for (int l = 0; l < LANES; l++) begin
        acc_q[l] <= '0;
        res_q[l] <= '0;
      end
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      out_valid <= v2;
      for (int l = 0; l < LANES; l++) begin
        if (acc_clr) acc_q[l] <= '0;
        else if (v1) acc_q[l] <= (acc_en1 ? acc_q[l] : '0) + AW'(sum_d[l]);
        if (v2) begin
          if (rnd[l] > maxv)      res_q[l] <= W'(MAXI);
          else if (rnd[l] < minv) res_q[l] <= W'(MINI);
          else                    res_q[l] <= rnd[l][W-1:0];
        end
      end
    end
  end

  // stage 3 input: round half up, drop fraction
  always_comb
    for (int l = 0; l < LANES; l++)
      rnd[l] = (acc_q[l] + AW'(2**(FRAC-1))) >>> FRAC;

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign result[l*W +: W] = res_q[l];

    assert_sat_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (v2 && rnd[l] > maxv) |=> (res_q[l] == W'(MAXI)));
    assert_sat_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (v2 && rnd[l] < minv) |=> (res_q[l] == W'(MINI)));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_clr |=> (acc_q[l] == '0));
  end

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(result));
  assert_known_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !$isunknown({mode, acc_en}));
endmodule

// File: tb/sim_conv_dot_engine.sv
`timescale 1ns/1ps
module sim_conv_dot_engine;
  localparam int L = 6, T = 25, W = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, mode, acc_en, acc_clr, out_valid;
  logic [L*T*W-1:0] data_in, weight_in;
  logic [L*W-1:0] result;

  conv_dot_engine u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .acc_en(acc_en), .acc_clr(acc_clr), .data_in(data_in), .weight_in(weight_in),
    .out_valid(out_valid), .result(result));

  int errors = 0, checks = 0, cyc = 0, n_iss = 0, n_out = 0;
  bit done = 0;
  int dv [L][T];
  int wv [L][T];
  longint macc [L];
  int exp_res [512][L];
  int exp_cyc [512];
  string exp_req [512];

  always @(posedge clk) cyc++;

  function automatic int conv_out(longint s);
    longint r = (s + 32) >>> 6;
    if (r > 2047) return 2047;
    if (r < -2048) return -2048;
    return int'(r);
  endfunction

  task automatic fill(int span);
    for (int l = 0; l < L; l++)
      for (int t = 0; t < T; t++) begin
        dv[l][t] = int'($urandom_range(0, 2*span)) - span;
        wv[l][t] = int'($urandom_range(0, 2*span)) - span;
      end
  endtask

  // caller is at a negedge; inputs stay for one cycle unless the next issue follows
  task automatic issue(bit md, bit ae, string req);
    for (int l = 0; l < L; l++) begin
      longint s = 0;
      for (int t = 0; t < T; t++) begin
        data_in[(l*T+t)*W +: W]   = W'(dv[l][t]);
        weight_in[(l*T+t)*W +: W] = W'(wv[l][t]);
        s += longint'(md ? dv[l][t] : dv[0][t]) * longint'(wv[l][t]);
      end
      macc[l] = (ae ? macc[l] : 0) + s;
      exp_res[n_iss][l] = conv_out(macc[l]);
    end
    exp_cyc[n_iss] = cyc;
    exp_req[n_iss] = req;
    n_iss++;
    mode = md; acc_en = ae; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (n_out >= n_iss) begin
        errors++; checks++;
        $display("FAIL R6: unexpected out_valid, got 1 expected 0");
      end else begin
        checks++;
        if (cyc != exp_cyc[n_out] + 3) begin
          errors++;
          $display("FAIL R6: set %0d out at cycle %0d expected %0d", n_out, cyc, exp_cyc[n_out] + 3);
        end
        for (int l = 0; l < L; l++) begin
          checks++;
          if ($signed(result[l*W +: W]) != exp_res[n_out][l]) begin
            errors++;
            $display("FAIL %s: set %0d lane %0d got %0d expected %0d", exp_req[n_out], n_out, l,
                     $signed(result[l*W +: W]), exp_res[n_out][l]);
          end
        end
        n_out++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, got %0d results expected %0d", n_out, n_iss);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [L*W-1:0] held;
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 1'b0; mode = 1'b0; acc_en = 1'b0; acc_clr = 1'b0;
    data_in = '0; weight_in = '0;
    for (int l = 0; l < L; l++) macc[l] = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '0) begin
      errors++;
      $display("FAIL R10: reset out_valid=%b result=%h expected 0", out_valid, result);
    end
    rst_n = 1'b1;
    idle(2);

    // R10: accumulators empty after reset, accumulate-on first pass equals chunk alone
    fill(40); issue(1'b1, 1'b1, "R10");
    // R1 zeros
    for (int l = 0; l < L; l++) for (int t = 0; t < T; t++) begin dv[l][t] = 0; wv[l][t] = 0; end
    issue(1'b1, 1'b0, "R1");
    // R2: convolution broadcast, other lanes' data differ
    fill(60); issue(1'b0, 1'b0, "R2");
    // R3: dot mode on the same operands
    issue(1'b1, 1'b0, "R3");
    // R4: half-LSB cases in lanes 0..2
    for (int l = 0; l < L; l++) for (int t = 0; t < T; t++) begin dv[l][t] = 0; wv[l][t] = 0; end
    dv[0][0] = 1;  wv[0][0] = 32;
    dv[1][0] = -1; wv[1][0] = 32;
    dv[2][0] = -1; wv[2][0] = 33;
    dv[3][0] = 1;  wv[3][0] = 31;
    issue(1'b1, 1'b0, "R4");
    // R5: positive and negative saturation
    for (int l = 0; l < L; l++) for (int t = 0; t < T; t++) begin
      dv[l][t] = 2047; wv[l][t] = (l < 3) ? 2047 : -2048;
    end
    issue(1'b1, 1'b0, "R5");
    for (int l = 0; l < L; l++) for (int t = 0; t < T; t++) begin
      dv[l][t] = -2048; wv[l][t] = -2048;
    end
    issue(1'b0, 1'b0, "R5");
    idle(5);

    // R9: result held while idle
    held = result;
    idle(4);
    checks++;
    if (result !== held) begin
      errors++;
      $display("FAIL R9: result %h changed while idle, expected %h", result, held);
    end

    // R7: three chained chunks, back to back
    fill(30); issue(1'b1, 1'b0, "R7");
    fill(30); issue(1'b1, 1'b1, "R7");
    fill(30); issue(1'b1, 1'b1, "R7");
    idle(5);

    // R8: clear then accumulate-on pass sees only the new chunk
    acc_clr = 1'b1; @(negedge clk); acc_clr = 1'b0;
    for (int l = 0; l < L; l++) macc[l] = 0;
    fill(50); issue(1'b1, 1'b1, "R8");
    idle(5);

    // R6 with R1/R7: random stream, back to back and with gaps
    for (int i = 0; i < 300; i++) begin
      int sp;
      sp = ($urandom_range(0, 3) == 0) ? 2047 : int'($urandom_range(4, 200));
      fill(sp);
      issue(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0), "R6");
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 4)));
    end
    idle(8);

    checks++;
    if (n_out != n_iss) begin
      errors++;
      $display("FAIL R6: got %0d results expected %0d", n_out, n_iss);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule